// File: doc/BRIEF.md
# Clock Power Mode Controller

This block decides which clocks of a small subsystem run, according to one of four power modes that software writes. It drives registered enables for the two main clock sources (a fast PLL clock and a slower local oscillator clock), for the bus clock, and for a group of peripheral clocks. It also produces a one-cycle tick enable at a programmable fraction of the main clock rate for slow serial peripherals.

A mode change runs as a short hardware sequence. First every domain enable drops. If the main source has to change, the old source is switched off and both sources stay off for two cycles before the new source is enabled. The new domain enables are applied last. While the sequence runs, a busy flag is high. Further requests are held in a one-entry slot, where the latest write wins, and that request runs once the sequence ends. Sleep stops every clock. Only the external wake input ends Sleep, and it restores the mode that was active before Sleep was entered.

Top module: `clk_pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is Normal (code 00), the PLL source enable, the bus enable and all peripheral enables are 1, the local source enable, busy and done are 0, the retain mask is all ones and the tick ratio is 1, so the tick is high on every cycle.
- R2: Mode codes are 00 Normal (PLL source, bus on, all peripherals on), 01 Slow (local source, bus on, all peripherals on), 10 Low-Power (local source, bus off, peripheral bit i on only where retain mask bit i is 1) and 11 Sleep (no source, bus off, all peripherals off).
- R3: The PLL and local source enables are never 1 together. When a change alters the source, the old source turns off on the second edge after the start, and the new source turns on on the fourth edge.
- R4: The start edge raises busy and clears the bus and peripheral enables. The mode output changes only on the edge where done pulses high for one cycle and busy falls. That is the fifth edge, counting the start, when the source changes, and the third edge otherwise.
- R5: Mode writes made while busy are held, the last one overriding earlier ones. The held request starts on the edge right after the current change completes.
- R6: Writing the mode that is already current, while idle, starts nothing. Busy and done stay 0.
- R7: In Low-Power mode, a write to the retain mask shows on the peripheral enables from the second edge after the write.
- R8: Once Sleep is reached, mode writes are discarded, including a request held from the sequence that entered Sleep. All enables stay 0 until wake.
- R9: A wake input seen in Sleep starts a change back to the mode that was current when Sleep was requested, with the R3/R4 timing.
- R10: The divider value v (0 to 255) gives a tick period of v+1 cycles with one-cycle pulses. A write restarts the count, so the first pulse comes v+1 edges after the write edge.
- R11: The tick stays 0 on any cycle that follows a cycle with no source enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | Requested mode code |
| retain_wr | input | 1 | Retain mask write strobe |
| retain_wdata | input | NUM_PERI | Peripherals kept running in Low-Power |
| div_wr | input | 1 | Divider value write strobe |
| div_wdata | input | DIV_W | Divider value, period = value + 1 |
| wake | input | 1 | Wake request, acted on only in Sleep |
| pll_clk_en | output | 1 | Enable of the fast PLL source |
| loc_clk_en | output | 1 | Enable of the local source |
| bus_clk_en | output | 1 | Bus clock enable |
| peri_clk_en | output | NUM_PERI | Peripheral clock enables |
| slow_tick | output | 1 | Divided one-cycle enable pulse |
| cur_mode | output | 2 | Mode in force |
| busy | output | 1 | Mode change in progress |
| done | output | 1 | One-cycle pulse as a change completes |

## Verification
Every result has a fixed edge count from its stimulus. The busy rise and the gate drop come on the write edge. Both sources are off after edges two and three, and the new source is on after edge four. Done and the new mode come after edge five (or after edge three when the source stays the same), and a retain change shows after the second edge. The bench drives at the falling edge, steps one rising edge at a time, and samples at the next falling edge, comparing each result on exactly its due cycle. For the divider, it counts edges from the write edge to each pulse for every value 0 to 255.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL = 2'b00,
    PM_SLOW   = 2'b01,
    PM_LOWPWR = 2'b10,
    PM_SLEEP  = 2'b11
  } pmode_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_PLL  = 2'b01,
    SRC_LOC  = 2'b10
  } src_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_SRC   = 2'b01,
    ST_GAP   = 2'b10,
    ST_APPLY = 2'b11
  } seq_st_e;

  // main source wanted by each mode
  function automatic src_e mode_src(pmode_e m);
    case (m)
      PM_NORMAL: return SRC_PLL;
      PM_SLOW:   return SRC_LOC;
      PM_LOWPWR: return SRC_LOC;
      default:   return SRC_NONE;
    endcase
  endfunction

  // bus clock runs only in the two full-speed modes
  function automatic logic mode_bus(pmode_e m);
    return (m == PM_NORMAL) || (m == PM_SLOW);
  endfunction

  // all peripherals run in the full-speed modes
  function automatic logic mode_peri_all(pmode_e m);
    return (m == PM_NORMAL) || (m == PM_SLOW);
  endfunction

  // peripherals follow the retain mask in low-power mode
  function automatic logic mode_peri_masked(pmode_e m);
    return m == PM_LOWPWR;
  endfunction

endpackage

// File: rtl/cpm_tick_div.sv
module cpm_tick_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             run,
  output logic             tick,
  output logic             wrap_evt
);

  logic [DIV_W-1:0] lim_q;
  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;

  assign wrap_evt = run && (cnt_q == lim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q  <= '0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (div_wr) begin
      lim_q  <= div_wdata;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (!run) begin
      tick_q <= 1'b0;
    end else if (wrap_evt) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick = tick_q;

endmodule

// File: rtl/cpm_mode_seq.sv
module cpm_mode_seq
  import cpm_pkg::*;
#(
  parameter int NUM_PERI     = 4,
  parameter int BREAK_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_wr,
  input  logic [1:0]          req_mode,
  input  logic                wake,
  input  logic [NUM_PERI-1:0] retain,
  output logic [1:0]          cur_mode,
  output logic                busy,
  output logic                done,
  output logic                pll_en,
  output logic                loc_en,
  output logic                bus_en,
  output logic [NUM_PERI-1:0] peri_en,
  output logic                start_evt,
  output logic                gap_evt
);

  localparam int GAP_W = (BREAK_CYCLES < 2) ? 1 : $clog2(BREAK_CYCLES);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(BREAK_CYCLES - 1);

  seq_st_e             st_q;
  pmode_e              cur_q, tgt_q, saved_q, pend_mode_q;
  logic                pend_vld_q;
  logic [GAP_W-1:0]    gap_cnt_q;
  logic                pll_q, loc_q, bus_q, busy_q, done_q;
  logic [NUM_PERI-1:0] peri_q;

  pmode_e wr_mode, cand_mode, start_mode;
  src_e   cur_src;
  logic   cand_vld, in_sleep, go_wake, go_req, src_diff;

  function automatic logic [NUM_PERI-1:0] peri_mask(pmode_e m, logic [NUM_PERI-1:0] r);
    if (mode_peri_all(m))    return '1;
    if (mode_peri_masked(m)) return r;
    return '0;
  endfunction

  always_comb begin
    wr_mode    = pmode_e'(req_mode);
    cand_vld   = req_wr | pend_vld_q;
    cand_mode  = req_wr ? wr_mode : pend_mode_q;
    in_sleep   = (cur_q == PM_SLEEP);
    go_wake    = (st_q == ST_IDLE) && in_sleep && wake;
    go_req     = (st_q == ST_IDLE) && !in_sleep && cand_vld && (cand_mode != cur_q);
    start_mode = go_wake ? saved_q : cand_mode;
    cur_src    = pll_q ? SRC_PLL : (loc_q ? SRC_LOC : SRC_NONE);
    src_diff   = (mode_src(tgt_q) != cur_src);
  end

  assign start_evt = go_wake | go_req;
  assign gap_evt   = (st_q == ST_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cur_q       <= PM_NORMAL;
      tgt_q       <= PM_NORMAL;
      saved_q     <= PM_NORMAL;
      pend_mode_q <= PM_NORMAL;
      pend_vld_q  <= 1'b0;
      gap_cnt_q   <= '0;
      pll_q       <= 1'b1;
      loc_q       <= 1'b0;
      bus_q       <= 1'b1;
      peri_q      <= '1;
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          pend_vld_q <= 1'b0;
          if (start_evt) begin
            tgt_q  <= start_mode;
            if (start_mode == PM_SLEEP) saved_q <= cur_q;
            busy_q <= 1'b1;
            bus_q  <= 1'b0;
            peri_q <= '0;
            st_q   <= ST_SRC;
          end else begin
            bus_q  <= mode_bus(cur_q);
            peri_q <= peri_mask(cur_q, retain);
          end
        end
        ST_SRC: begin
          if (src_diff) begin
            pll_q     <= 1'b0;
            loc_q     <= 1'b0;
            gap_cnt_q <= '0;
            st_q      <= ST_GAP;
          end else begin
            st_q <= ST_APPLY;
          end
        end
        ST_GAP: begin
          if (gap_cnt_q == GAP_LAST) begin
            pll_q <= (mode_src(tgt_q) == SRC_PLL);
            loc_q <= (mode_src(tgt_q) == SRC_LOC);
            st_q  <= ST_APPLY;
          end else begin
            gap_cnt_q <= gap_cnt_q + 1'b1;
          end
        end
        default: begin
          cur_q  <= tgt_q;
          bus_q  <= mode_bus(tgt_q);
          peri_q <= peri_mask(tgt_q, retain);
          busy_q <= 1'b0;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
      endcase
      if ((st_q != ST_IDLE) && req_wr) begin
        pend_vld_q  <= 1'b1;
        pend_mode_q <= wr_mode;
      end
    end
  end

  assign cur_mode = cur_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign pll_en   = pll_q;
  assign loc_en   = loc_q;
  assign bus_en   = bus_q;
  assign peri_en  = peri_q;

endmodule

// File: rtl/clk_pwr_mode_ctrl.sv
module clk_pwr_mode_ctrl #(
  parameter int NUM_PERI     = 4,
  parameter int DIV_W        = 8,
  parameter int BREAK_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_wr,
  input  logic [1:0]          mode_wdata,
  input  logic                retain_wr,
  input  logic [NUM_PERI-1:0] retain_wdata,
  input  logic                div_wr,
  input  logic [DIV_W-1:0]    div_wdata,
  input  logic                wake,
  output logic                pll_clk_en,
  output logic                loc_clk_en,
  output logic                bus_clk_en,
  output logic [NUM_PERI-1:0] peri_clk_en,
  output logic                slow_tick,
  output logic [1:0]          cur_mode,
  output logic                busy,
  output logic                done
);

  logic [NUM_PERI-1:0] retain_q;
  logic                start_evt, gap_evt, src_on, wrap_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         retain_q <= '1;
    else if (retain_wr) retain_q <= retain_wdata;
  end

  cpm_mode_seq #(
    .NUM_PERI    (NUM_PERI),
    .BREAK_CYCLES(BREAK_CYCLES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_wr   (mode_wr),
    .req_mode (mode_wdata),
    .wake     (wake),
    .retain   (retain_q),
    .cur_mode (cur_mode),
    .busy     (busy),
    .done     (done),
    .pll_en   (pll_clk_en),
    .loc_en   (loc_clk_en),
    .bus_en   (bus_clk_en),
    .peri_en  (peri_clk_en),
    .start_evt(start_evt),
    .gap_evt  (gap_evt)
  );

  assign src_on = pll_clk_en | loc_clk_en;

  cpm_tick_div #(
    .DIV_W(DIV_W)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_wr   (div_wr),
    .div_wdata(div_wdata),
    .run      (src_on),
    .tick     (slow_tick),
    .wrap_evt (wrap_evt)
  );

endmodule

// File: rtl/cpm_checker.sv
module cpm_checker #(
  parameter int NUM_PERI = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wake,
  input logic                pll_clk_en,
  input logic                loc_clk_en,
  input logic                bus_clk_en,
  input logic [NUM_PERI-1:0] peri_clk_en,
  input logic                slow_tick,
  input logic [1:0]          cur_mode,
  input logic                busy,
  input logic                done,
  input logic                start_evt,
  input logic                gap_evt
);

  p_src_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(pll_clk_en && loc_clk_en));

  p_pll_after_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_clk_en) |-> (!$past(loc_clk_en) && !$past(loc_clk_en, 2)));

  p_loc_after_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loc_clk_en) |-> (!$past(pll_clk_en) && !$past(pll_clk_en, 2)));

  p_gap_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gap_evt |-> (!pll_clk_en && !loc_clk_en));

  p_start_gates_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (busy && !bus_clk_en && (peri_clk_en == '0)));

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_mode_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_mode) |-> done);

  p_lowpwr_bus_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'b10 && !busy) |-> !bus_clk_en);

  p_sleep_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'b11 && !busy) |->
      (!pll_clk_en && !loc_clk_en && !bus_clk_en && (peri_clk_en == '0)));

  p_sleep_needs_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'b11 && !busy && !wake) |=> !busy);

  p_tick_needs_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    slow_tick |-> $past(pll_clk_en || loc_clk_en));

endmodule

bind clk_pwr_mode_ctrl cpm_checker #(.NUM_PERI(NUM_PERI)) u_cpm_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wake       (wake),
  .pll_clk_en (pll_clk_en),
  .loc_clk_en (loc_clk_en),
  .bus_clk_en (bus_clk_en),
  .peri_clk_en(peri_clk_en),
  .slow_tick  (slow_tick),
  .cur_mode   (cur_mode),
  .busy       (busy),
  .done       (done),
  .start_evt  (start_evt),
  .gap_evt    (gap_evt)
);

// File: tb/test_clk_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_clk_pwr_mode_ctrl;

  localparam int NP = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_wr = 1'b0;
  logic [1:0]    mode_wdata = 2'b00;
  logic          retain_wr = 1'b0;
  logic [NP-1:0] retain_wdata = '0;
  logic          div_wr = 1'b0;
  logic [DW-1:0] div_wdata = '0;
  logic          wake = 1'b0;
  logic          pll_clk_en, loc_clk_en, bus_clk_en, slow_tick, busy, done;
  logic [NP-1:0] peri_clk_en;
  logic [1:0]    cur_mode;

  int errors = 0;
  int checks = 0;
  int bcur   = 0;
  logic [NP-1:0] bret = '1;

  always #2 clk = ~clk;

  clk_pwr_mode_ctrl #(.NUM_PERI(NP), .DIV_W(DW), .BREAK_CYCLES(2)) i_clk_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .retain_wr(retain_wr), .retain_wdata(retain_wdata), .div_wr(div_wr),
    .div_wdata(div_wdata), .wake(wake), .pll_clk_en(pll_clk_en),
    .loc_clk_en(loc_clk_en), .bus_clk_en(bus_clk_en), .peri_clk_en(peri_clk_en),
    .slow_tick(slow_tick), .cur_mode(cur_mode), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // 0 none, 1 pll, 2 local
  function automatic int src_of(int m);
    return (m == 0) ? 1 : (m == 3) ? 0 : 2;
  endfunction

  function automatic int exp_outs(int m);
    int s, pm, b;
    s  = src_of(m);
    b  = (m < 2) ? 1 : 0;
    pm = (m < 2) ? ((1 << NP) - 1) : (m == 2) ? int'(bret) : 0;
    return ((s == 1 ? 1 : 0) << (NP + 2)) | ((s == 2 ? 1 : 0) << (NP + 1)) | (b << NP) | pm;
  endfunction

  function automatic int act_outs();
    return int'({pll_clk_en, loc_clk_en, bus_clk_en, peri_clk_en});
  endfunction

  task automatic move(input int m, input bit use_wake);
    int  sf, st;
    bit  lng;
    sf  = src_of(bcur);
    st  = src_of(m);
    lng = (sf != st);
    if (use_wake) wake = 1'b1;
    else begin mode_wr = 1'b1; mode_wdata = m[1:0]; end
    step();
    wake = 1'b0; mode_wr = 1'b0;
    chk(busy && !bus_clk_en && peri_clk_en == '0, "R4", "start edge busy/gates",
        int'({busy, bus_clk_en, peri_clk_en}), 1 << (NP + 1));
    if (lng) begin
      step();
      chk(!pll_clk_en && !loc_clk_en, "R3", "sources off edge 2",
          int'({pll_clk_en, loc_clk_en}), 0);
      step();
      chk(!pll_clk_en && !loc_clk_en && busy, "R3", "sources off edge 3",
          int'({busy, pll_clk_en, loc_clk_en}), 4);
      step();
      chk(pll_clk_en == (st == 1) && loc_clk_en == (st == 2) && !done, "R3",
          "new source edge 4", int'({pll_clk_en, loc_clk_en}),
          ((st == 1) ? 2 : 0) | ((st == 2) ? 1 : 0));
      step();
    end else begin
      step();
      chk(busy && !done && int'(cur_mode) == bcur, "R4", "mid-change edge 2",
          int'(cur_mode), bcur);
      step();
    end
    chk(done && !busy && int'(cur_mode) == m, "R4", "completion mode",
        int'({done, busy, cur_mode}), 8 | m);
    chk(act_outs() == exp_outs(m), "R2", "enables after change", act_outs(), exp_outs(m));
    step();
    chk(!done, "R4", "done one cycle", int'(done), 0);
    bcur = m;
  endtask

  task automatic div_sweep();
    for (int v = 0; v < 256; v++) begin
      int first, second, pulses;
      first = -1; second = -1; pulses = 0;
      div_wr = 1'b1; div_wdata = v[DW-1:0];
      step();
      div_wr = 1'b0;
      for (int k = 1; k <= 2 * v + 2; k++) begin
        step();
        if (slow_tick) begin
          pulses++;
          if (first < 0) first = k;
          else if (second < 0) second = k;
        end
      end
      chk(first == v + 1 && second == 2 * v + 2 && pulses == 2, "R10",
          $sformatf("tick timing v=%0d", v), first * 1000 + second, (v + 1) * 1000 + 2 * v + 2);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(cur_mode == 2'b00 && !busy && !done, "R1", "reset mode/busy/done",
        int'({cur_mode, busy, done}), 0);
    chk(act_outs() == exp_outs(0), "R1", "reset enables", act_outs(), exp_outs(0));
    step();
    chk(slow_tick, "R1", "tick at ratio 1", int'(slow_tick), 1);
    step();
    chk(slow_tick, "R1", "tick every cycle", int'(slow_tick), 1);

    // R6 writing the current mode
    mode_wr = 1'b1; mode_wdata = 2'b00;
    step();
    mode_wr = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(!busy && !done && cur_mode == 2'b00, "R6", "same-mode write ignored",
          int'({busy, done, cur_mode}), 0);
      step();
    end

    // R2/R3/R4/R9 all transitions among the modes
    retain_wr = 1'b1; retain_wdata = 4'b1011; bret = 4'b1011;
    step();
    retain_wr = 1'b0;
    for (int f = 0; f < 3; f++) begin
      for (int t = 0; t < 4; t++) begin
        if (t != f) begin
          if (bcur != f) move(f, 1'b0);
          move(t, 1'b0);
          if (t == 3) move(f, 1'b1);  // R9 wake returns to the mode before Sleep
        end
      end
    end

    // R5 requests during a change: latest wins, starts after completion
    if (bcur != 0) move(0, 1'b0);
    mode_wr = 1'b1; mode_wdata = 2'b01;
    step();                              // E0 start
    mode_wdata = 2'b11;
    step();                              // E1 held Sleep
    mode_wdata = 2'b10;
    step();                              // E2 held Low-Power overrides
    mode_wr = 1'b0;
    step();                              // E3
    step();                              // E4 done Slow
    chk(done && cur_mode == 2'b01, "R5", "first change completes",
        int'({done, cur_mode}), 5);
    step();                              // E5 held request starts
    chk(busy && !done, "R5", "held request starts next edge", int'({busy, done}), 2);
    step();
    step();                              // E7 done Low-Power
    chk(done && cur_mode == 2'b10, "R5", "latest held request applied",
        int'({done, cur_mode}), 6);
    bcur = 2;
    step();

    // R7 retain mask in Low-Power
    retain_wr = 1'b1; retain_wdata = 4'b0101;
    step();
    retain_wr = 1'b0;
    chk(peri_clk_en == 4'b1011, "R7", "old mask at write edge", int'(peri_clk_en), 'hb);
    step();
    chk(peri_clk_en == 4'b0101, "R7", "new mask second edge", int'(peri_clk_en), 'h5);
    bret = 4'b0101;

    // R8 held request discarded once Sleep is reached
    mode_wr = 1'b1; mode_wdata = 2'b11;
    step();
    mode_wdata = 2'b00;
    step();
    mode_wr = 1'b0;
    repeat (3) step();
    chk(cur_mode == 2'b11, "R8", "Sleep reached", int'(cur_mode), 3);
    repeat (3) step();
    chk(!busy && cur_mode == 2'b11, "R8", "held request dropped in Sleep",
        int'({busy, cur_mode}), 3);
    mode_wr = 1'b1; mode_wdata = 2'b01;
    step();
    mode_wr = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(!busy && cur_mode == 2'b11 && act_outs() == 0, "R8", "write in Sleep ignored",
          act_outs(), 0);
      chk(!slow_tick, "R11", "no tick without source", int'(slow_tick), 0);
    end
    bcur = 3;
    move(2, 1'b1);                      // R9 wake restores Low-Power
    move(0, 1'b0);

    // R10 divider sweep over every value
    div_sweep();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule